// File: doc/BRIEF.md
# Boot-Block Flash Command Front End

This block sits between a host bus and an abstract word-wide flash cell array. The host issues single-cycle write strobes carrying an address and a data word. The low byte of the data word is decoded as a command. The commands select what a host read returns: array contents, the status register or identification words. They can also clear the sticky error flags, or start a two-cycle program or erase sequence. A small write state machine carries out accepted program and erase operations. It reports readiness and failures through an 8-bit status register that the host can poll at any time, including while an operation is in progress.

Every word address belongs to one of seven erase blocks:

- one boot block;
- two small parameter blocks;
- one main block of three-quarters size;
- three full-size main blocks.

A parameter selects one of two arrangements. The bottom-boot arrangement puts the boot block at the lowest addresses. The top-boot arrangement mirrors the whole map to the highest addresses. All block sizes are derived from the address width, so a narrow build keeps the same proportions.

Two inputs gate what may change memory. A low-programming-voltage input rejects every program and erase. A lock input guards only the boot block. The parameter blocks are never protected.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode: a host read returns `mem_rdata` for `bus_addr`. The status register reads 0x80 (bit 7 = ready, error bits 5, 4 and 3 all clear).
- R2: The command byte (low byte of `bus_wdata`) has these effects. 0x70 selects status read. 0xFF selects array read. 0x90 selects identifier read, where a read with address bit 0 = 0 returns `MFG_ID` (default 0x00C2) and a read with bit 0 = 1 returns the device identifier (0x4471 bottom-boot, 0x4470 top-boot by default). Any other byte outside a sequence leaves the mode unchanged.
- R3: Writing 0x40 and then any word at address A programs that word into A. The block is busy (status bit 7 = 0) for exactly `PROG_CYCLES` cycles after the confirm cycle. The mode is then status read.
- R4: Writing 0x20 and then 0xD0 at address A fills every word of the block containing A with all ones. It spends `ERASE_WORD_CYCLES` busy cycles per word, and leaves words outside that block unchanged.
- R5: Bottom-boot map, as fractions of the 2^ADDR_W address space:
  - the boot block is the first 1/32;
  - the two parameter blocks are each the next 1/64;
  - the main block of three-quarters size ends at 1/4;
  - three 1/4 main blocks follow.

  At ADDR_W = 18 these are 0x00000–0x01FFF, 0x02000–0x02FFF, 0x03000–0x03FFF, 0x04000–0x0FFFF and 0x10000–0x3FFFF.
- R6: Top-boot map is the bit-inverted mirror of R5. At ADDR_W = 18 the boot block is 0x3E000–0x3FFFF, the parameter blocks are 0x3D000–0x3DFFF and 0x3C000–0x3CFFF, the three-quarter main block is 0x30000–0x3BFFF, and 0x00000–0x2FFFF holds the three full main blocks.
- R7: While `vpp_low` = 1, a program or erase confirm changes no memory and does not make the block busy. It sets status bit 3 together with bit 4 (program) or bit 5 (erase). Status read, array read, identifier read and clear status keep working.
- R8: With `boot_lock` = 1, a program or erase aimed at the boot block changes no memory and sets bit 4 or bit 5 respectively. Parameter and main blocks are still programmed and erased.
- R9: After 0x20, a confirm byte other than 0xD0 sets both bit 5 and bit 4, leaves the block in status-read mode, and erases nothing.
- R10: Error bits 5, 4 and 3 stay set through other commands and operations until a 0x50 command clears them.
- R11: While busy, host reads return the status register (bit 7 = 0) whatever the mode. Host writes are ignored: they neither change the mode nor start an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host word address for reads and write cycles |
| bus_wdata | input | DATA_W | Host write data; low byte is the command |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W | Host read data (array, status or identifier) |
| vpp_low | input | 1 | Programming voltage below lockout level |
| boot_lock | input | 1 | Protect the boot block |
| mem_addr | output | ADDR_W | Cell array address |
| mem_wdata | output | DATA_W | Cell array write data |
| mem_we | output | 1 | Cell array write enable |
| mem_rdata | input | DATA_W | Cell array read data |

## Verification
The bench builds two copies side by side on one shared host bus: one with TOP_BOOT = 0 and one with TOP_BOOT = 1. Both use ADDR_W = 10, PROG_CYCLES = 4 and ERASE_WORD_CYCLES = 2. The narrow address space shrinks the blocks to 32, 16, 16, 192 and 256 words. Every block, including a full-size main block, can therefore be erased and compared word by word within a short run. The same command stream lands in different blocks of the two maps. This brings the mirrored boundaries, the boot-lock asymmetry and the differing busy lengths into view in a single sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_OK    = 8'hD0;

  typedef enum logic [2:0] {
    M_ARRAY,
    M_STATUS,
    M_IDENT,
    M_PSETUP,
    M_ESETUP
  } host_mode_t;

  typedef enum logic [1:0] {
    W_IDLE,
    W_PROG,
    W_ERASE
  } wsm_state_t;

  // error vector layout inside the state machine: {erase, program, lockout}
  localparam int ERR_ERASE = 2;
  localparam int ERR_PROG  = 1;
  localparam int ERR_VOLT  = 0;

  function automatic logic [7:0] pack_status(input logic ready, input logic [2:0] err);
    return {ready, 1'b0, err[ERR_ERASE], err[ERR_PROG], err[ERR_VOLT], 3'b000};
  endfunction

endpackage

// File: rtl/flash_block_map.sv
module flash_block_map #(
  parameter int ADDR_W   = 18,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        blk_idx,
  output logic [ADDR_W-1:0] blk_first,
  output logic [ADDR_W-1:0] blk_last,
  output logic              blk_is_boot
);

  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] PAR_SZ  = AW1'(1) << (ADDR_W - 6);
  localparam logic [AW1-1:0] QUARTER = AW1'(1) << (ADDR_W - 2);
  localparam logic [AW1-1:0] SPACE   = AW1'(1) << ADDR_W;

  // start of each block in the bottom-boot numbering, index 7 = end of space
  function automatic logic [AW1-1:0] start_of(input logic [2:0] idx);
    case (idx)
      3'd0:    return '0;
      3'd1:    return PAR_SZ * 2;
      3'd2:    return PAR_SZ * 3;
      3'd3:    return PAR_SZ * 4;
      3'd4:    return QUARTER;
      3'd5:    return QUARTER * 2;
      3'd6:    return QUARTER * 3;
      default: return SPACE;
    endcase
  endfunction

  function automatic logic [2:0] index_of(input logic [ADDR_W-1:0] a);
    logic [AW1-1:0] wa;
    logic [2:0]     r;
    wa = {1'b0, a};
    r  = 3'd6;
    for (int k = 5; k >= 0; k--) begin
      if (wa < start_of(3'(k + 1))) r = 3'(k);
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] norm_addr;
  logic [AW1-1:0]    b_first_w;
  logic [AW1-1:0]    b_last_w;
  logic [ADDR_W-1:0] b_first;
  logic [ADDR_W-1:0] b_last;

  always_comb begin
    norm_addr = TOP_BOOT ? ~addr : addr;
    blk_idx   = index_of(norm_addr);
    b_first_w = start_of(blk_idx);
    b_last_w  = start_of(blk_idx + 3'd1) - AW1'(1);
    b_first   = b_first_w[ADDR_W-1:0];
    b_last    = b_last_w[ADDR_W-1:0];
  end

  generate
    if (TOP_BOOT) begin : g_top
      assign blk_first = ~b_last;
      assign blk_last  = ~b_first;
    end else begin : g_bottom
      assign blk_first = b_first;
      assign blk_last  = b_last;
    end
  endgenerate

  assign blk_is_boot = (blk_idx == 3'd0);

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] cmd_byte,
  input  logic       busy,
  output host_mode_t mode,
  output logic       wsm_start,
  output logic       wsm_erase,
  output logic       seq_err,
  output logic       clr_status
);

  host_mode_t mode_q, mode_d;
  logic       wr_ok;

  assign wr_ok = bus_we && !busy;

  always_comb begin
    mode_d     = mode_q;
    wsm_start  = 1'b0;
    wsm_erase  = 1'b0;
    seq_err    = 1'b0;
    clr_status = 1'b0;
    if (wr_ok) begin
      case (mode_q)
        M_PSETUP: begin
          wsm_start = 1'b1;
          mode_d    = M_STATUS;
        end
        M_ESETUP: begin
          if (cmd_byte == CMD_ERASE_OK) begin
            wsm_start = 1'b1;
            wsm_erase = 1'b1;
          end else begin
            seq_err = 1'b1;
          end
          mode_d = M_STATUS;
        end
        default: begin
          case (cmd_byte)
            CMD_READ_ARRAY:  mode_d = M_ARRAY;
            CMD_READ_STATUS: mode_d = M_STATUS;
            CMD_READ_ID:     mode_d = M_IDENT;
            CMD_CLEAR_STAT:  clr_status = 1'b1;
            CMD_PROG_SETUP:  mode_d = M_PSETUP;
            CMD_ERASE_SETUP: mode_d = M_ESETUP;
            default:         mode_d = mode_q;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= M_ARRAY;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // writes during a busy operation leave the mode alone
  assert_mode_held_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we) |=> $stable(mode_q));

  // a finished setup/confirm pair always lands in status read
  assert_confirm_to_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (mode_q == M_ESETUP || mode_q == M_PSETUP)) |=> (mode_q == M_STATUS));

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W            = 18,
  parameter int DATA_W            = 16,
  parameter int PROG_CYCLES       = 8,
  parameter int ERASE_WORD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic              seq_err,
  input  logic              clr_status,
  input  logic              vpp_low,
  input  logic              boot_lock,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic [ADDR_W-1:0] blk_first,
  input  logic [ADDR_W-1:0] blk_last,
  input  logic              blk_is_boot,
  output logic              busy,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  localparam int CNT_MAX = (PROG_CYCLES > ERASE_WORD_CYCLES) ? PROG_CYCLES : ERASE_WORD_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  function automatic logic [CW-1:0] reload(input logic erase);
    return erase ? CW'(ERASE_WORD_CYCLES - 1) : CW'(PROG_CYCLES - 1);
  endfunction

  wsm_state_t        state_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] cur_q, first_q, last_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        err_q;

  logic volt_reject, lock_reject, accept, word_done, last_word;
  logic [2:0] op_bit;

  assign op_bit      = {op_erase, !op_erase, 1'b0};
  assign volt_reject = start && vpp_low;
  assign lock_reject = start && !vpp_low && boot_lock && blk_is_boot;
  assign accept      = start && !vpp_low && !(boot_lock && blk_is_boot);
  assign word_done   = (state_q != W_IDLE) && (cnt_q == '0);
  assign last_word   = (cur_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      data_q  <= '0;
      err_q   <= '0;
    end else begin
      case (state_q)
        W_IDLE: begin
          if (seq_err)     err_q <= err_q | 3'b110;
          if (clr_status)  err_q <= '0;
          if (volt_reject) err_q <= err_q | op_bit | 3'b001;
          if (lock_reject) err_q <= err_q | op_bit;
          if (accept) begin
            state_q <= op_erase ? W_ERASE : W_PROG;
            cur_q   <= op_erase ? blk_first : tgt_addr;
            first_q <= blk_first;
            last_q  <= blk_last;
            data_q  <= tgt_data;
            cnt_q   <= reload(op_erase);
          end
        end
        W_PROG: begin
          if (word_done) state_q <= W_IDLE;
          else           cnt_q   <= cnt_q - CW'(1);
        end
        W_ERASE: begin
          if (word_done) begin
            if (last_word) begin
              state_q <= W_IDLE;
            end else begin
              cur_q <= cur_q + ADDR_W'(1);
              cnt_q <= reload(1'b1);
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != W_IDLE);
  assign status    = pack_status(!busy, err_q);
  assign mem_addr  = cur_q;
  assign mem_wdata = (state_q == W_ERASE) ? {DATA_W{1'b1}} : data_q;
  assign mem_we    = word_done;

  assert_start_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  assert_lockout_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vpp_low) |=> (!busy && err_q[ERR_VOLT]));

  assert_locked_boot_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && boot_lock && blk_is_boot) |=> !busy);

  assert_erase_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state_q == W_ERASE) |-> (cur_q >= first_q && cur_q <= last_q));

  assert_errors_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W            = 18,
  parameter int          DATA_W            = 16,
  parameter bit          TOP_BOOT          = 1'b0,
  parameter int          PROG_CYCLES       = 8,
  parameter int          ERASE_WORD_CYCLES = 4,
  parameter logic [15:0] MFG_ID            = 16'h00C2,
  parameter logic [15:0] DEV_ID_BOT        = 16'h4471,
  parameter logic [15:0] DEV_ID_TOP        = 16'h4470
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              vpp_low,
  input  logic              boot_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam logic [15:0] DEV_ID = TOP_BOOT ? DEV_ID_TOP : DEV_ID_BOT;

  host_mode_t        mode;
  logic              wsm_start, wsm_erase, seq_err, clr_status, busy;
  logic [7:0]        status;
  logic [2:0]        blk_idx;
  logic [ADDR_W-1:0] blk_first, blk_last, wsm_addr;
  logic              blk_is_boot;

  flash_block_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) map_i (
    .addr        (bus_addr),
    .blk_idx     (blk_idx),
    .blk_first   (blk_first),
    .blk_last    (blk_last),
    .blk_is_boot (blk_is_boot)
  );

  flash_cmd_decode dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .cmd_byte   (bus_wdata[7:0]),
    .busy       (busy),
    .mode       (mode),
    .wsm_start  (wsm_start),
    .wsm_erase  (wsm_erase),
    .seq_err    (seq_err),
    .clr_status (clr_status)
  );

  flash_wsm #(
    .ADDR_W            (ADDR_W),
    .DATA_W            (DATA_W),
    .PROG_CYCLES       (PROG_CYCLES),
    .ERASE_WORD_CYCLES (ERASE_WORD_CYCLES)
  ) wsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (wsm_start),
    .op_erase    (wsm_erase),
    .seq_err     (seq_err),
    .clr_status  (clr_status),
    .vpp_low     (vpp_low),
    .boot_lock   (boot_lock),
    .tgt_addr    (bus_addr),
    .tgt_data    (bus_wdata),
    .blk_first   (blk_first),
    .blk_last    (blk_last),
    .blk_is_boot (blk_is_boot),
    .busy        (busy),
    .status      (status),
    .mem_addr    (wsm_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we)
  );

  assign mem_addr = busy ? wsm_addr : bus_addr;

  always_comb begin
    bus_rdata = DATA_W'(status);
    if (!busy) begin
      case (mode)
        M_ARRAY: bus_rdata = mem_rdata;
        M_IDENT: bus_rdata = bus_addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFG_ID);
        default: bus_rdata = DATA_W'(status);
      endcase
    end
  end

  assert_busy_reads_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_rdata[7] == 1'b0));

  assert_target_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |-> (blk_first <= bus_addr && bus_addr <= blk_last));

  assert_boot_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_is_boot && wsm_start) |-> (TOP_BOOT ? (blk_last == {ADDR_W{1'b1}}) : (blk_first == '0)));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int PC = 4;
  localparam int EC = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, vpp_low = 1'b0, boot_lock = 1'b0;
  logic [DW-1:0] rdb, rdt;
  logic [AW-1:0] mab, mat;
  logic [DW-1:0] mwb, mwt, mrb, mrt;
  logic mweb, mwet;

  logic [DW-1:0] memb [NW];
  logic [DW-1:0] memt [NW];
  logic [DW-1:0] expb [NW];
  logic [DW-1:0] expt [NW];

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TOP_BOOT(1'b0), .PROG_CYCLES(PC),
                   .ERASE_WORD_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(rdb), .vpp_low(vpp_low), .boot_lock(boot_lock), .mem_addr(mab),
    .mem_wdata(mwb), .mem_we(mweb), .mem_rdata(mrb));

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TOP_BOOT(1'b1), .PROG_CYCLES(PC),
                   .ERASE_WORD_CYCLES(EC)) dut_top_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(rdt), .vpp_low(vpp_low), .boot_lock(boot_lock), .mem_addr(mat),
    .mem_wdata(mwt), .mem_we(mwet), .mem_rdata(mrt));

  assign mrb = memb[mab];
  assign mrt = memt[mat];
  always @(posedge clk) begin
    if (mweb) memb[mab] <= mwb;
    if (mwet) memt[mat] <= mwt;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic rd_both(input int a, input int eb, input int et, input string tag);
    bus_addr = AW'(a);
    #1;
    chk(rdb == DW'(eb), {tag, " bottom"}, int'(rdb), eb);
    chk(rdt == DW'(et), {tag, " top"}, int'(rdt), et);
  endtask

  task automatic wait_done(output int cb, output int ct);
    cb = 0; ct = 0;
    for (int k = 0; k < 4000; k++) begin
      if (!rdb[7]) cb++;
      if (!rdt[7]) ct++;
      if (rdb[7] && rdt[7]) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < NW; i++) begin
      if (memb[i] !== expb[i]) bad++;
      if (memt[i] !== expt[i]) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic fill(input bit top, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      if (top) expt[i] = '1; else expb[i] = '1;
    end
  endtask

  task automatic t_reset;
    rd_both(5, int'(expb[5]), int'(expt[5]), "R1 array read after reset");
    wr(0, 'h70);
    rd_both(0, 'h80, 'h80, "R1 status after reset");
  endtask

  task automatic t_ident;
    wr(0, 'h90);
    rd_both(0, 'h00C2, 'h00C2, "R2 manufacturer id");
    rd_both(1, 'h4471, 'h4470, "R2 device id");
    wr(0, 'h13);
    rd_both(0, 'h00C2, 'h00C2, "R2 unknown byte keeps mode");
    wr(0, 'hFF);
    rd_both(7, int'(expb[7]), int'(expt[7]), "R2 back to array");
  endtask

  task automatic t_program;
    int cb, ct;
    wr(0, 'h40);
    wr(100, 'h1234);
    wait_done(cb, ct);
    chk(cb == PC && ct == PC, "R3 program busy length", cb, PC);
    expb[100] = 16'h1234; expt[100] = 16'h1234;
    rd_both(100, 'h80, 'h80, "R3 status after program");
    wr(0, 'hFF);
    rd_both(100, 'h1234, 'h1234, "R3 programmed word");
    cmp_mem("R3 memory after program");
  endtask

  task automatic t_erase_main;
    int cb, ct;
    wr(0, 'h20);
    wr(70, 'hD0);
    wait_done(cb, ct);
    chk(cb == 192 * EC, "R5 bottom three-quarter block erase length", cb, 192 * EC);
    chk(ct == 256 * EC, "R6 top full block erase length", ct, 256 * EC);
    fill(0, 64, 255);
    fill(1, 0, 255);
    cmp_mem("R4 R5 R6 erase extent");
  endtask

  task automatic t_lock;
    int cb, ct;
    boot_lock = 1'b1;
    wr(0, 'h20);
    wr(10, 'hD0);
    wait_done(cb, ct);
    chk(cb == 0, "R8 locked boot erase not busy", cb, 0);
    fill(1, 0, 255);
    rd_both(0, 'hA0, 'h80, "R8 locked erase status");
    wr(0, 'h40);
    wr(1000, 'hABCD);
    wait_done(cb, ct);
    expb[1000] = 16'hABCD;
    rd_both(0, 'hA0, 'h90, "R8 locked program status");
    cmp_mem("R8 boot block untouched");
    wr(0, 'hFF);
    wr(0, 'h70);
    rd_both(0, 'hA0, 'h90, "R10 errors sticky across commands");
    wr(0, 'h20);
    wr(980, 'hD0);
    wait_done(cb, ct);
    chk(ct == 16 * EC, "R8 parameter block erased under lock", ct, 16 * EC);
    fill(1, 976, 991);
    fill(0, 768, 1023);
    cmp_mem("R6 R8 parameter erase extent");
    rd_both(0, 'hA0, 'h90, "R10 errors sticky across operations");
    wr(0, 'h50);
    rd_both(0, 'h80, 'h80, "R10 clear status");
    boot_lock = 1'b0;
  endtask

  task automatic t_vpp;
    vpp_low = 1'b1;
    wr(0, 'h40);
    wr(300, 'h5A5A);
    rd_both(0, 'h98, 'h98, "R7 program rejected");
    wr(0, 'h20);
    wr(300, 'hD0);
    rd_both(0, 'hB8, 'hB8, "R7 erase rejected");
    cmp_mem("R7 memory unchanged");
    wr(0, 'h90);
    rd_both(1, 'h4471, 'h4470, "R7 id read under lockout");
    wr(0, 'h50);
    wr(0, 'h70);
    rd_both(0, 'h80, 'h80, "R7 clear under lockout");
    wr(0, 'hFF);
    rd_both(300, int'(expb[300]), int'(expt[300]), "R7 array read under lockout");
    vpp_low = 1'b0;
  endtask

  task automatic t_seq;
    wr(0, 'h20);
    wr(300, 'h33);
    rd_both(0, 'hB0, 'hB0, "R9 sequence error status");
    cmp_mem("R9 no erase on bad confirm");
    wr(0, 'h50);
    rd_both(0, 'h80, 'h80, "R9 cleared");
  endtask

  task automatic t_busy;
    int cb, ct;
    wr(0, 'h20);
    wr(300, 'hD0);
    rd_both(300, 'h00, 'h00, "R11 status read while busy");
    wr(0, 'hFF);
    wr(0, 'h40);
    wr(5, 'h1111);
    rd_both(5, 'h00, 'h00, "R11 still status after writes");
    wait_done(cb, ct);
    fill(0, 256, 511);
    fill(1, 256, 511);
    rd_both(5, 'h80, 'h80, "R11 mode unchanged by busy writes");
    cmp_mem("R11 busy writes ignored");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      memb[i] = DW'(i * 7 + 3) ^ 16'hA5A5;
      memt[i] = DW'(i * 7 + 3) ^ 16'hA5A5;
      expb[i] = memb[i];
      expt[i] = memt[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_ident();
    t_program();
    t_erase_main();
    t_lock();
    t_vpp();
    t_seq();
    t_busy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule